// File: doc/BRIEF.md
# Shared Coprocessor Program RAM Switch

This block holds the instruction store of a secondary signal-processing core. The store is one single-port RAM of 4096 words, each 16 bits wide (8 KB). The main core and the coprocessor's fetch port share it. A single enable bit decides which side owns the RAM. The bit clears on every reset, so after reset the main core owns the RAM.

While the coprocessor is disabled, the main core sees the RAM as a window in its data address map. The window covers word addresses 0x1000 through 0x1FFF. The main core uses this window to load program code, with whole-word writes and reads that return one cycle later. Once the main core sets the enable bit, the RAM serves only instruction fetches. Window reads from the main core then return zero and window writes are dropped. Each such access also sets a sticky error flag. Clearing the enable bit stops fetching at once and hands the RAM back to the main core.

Top module: `prog_ram_switch`

## Requirements
- R1: After reset, `dspEnable`, `dspFetchValid`, `accessErr` and `hostRvalid` are all 0.
- R2: A main-core access hits the window only when `hostSel` is 1 and `hostAddr` lies in 0x1000..0x1FFF. The RAM index is `hostAddr` minus 0x1000. Any access outside the window leaves the RAM unchanged and never raises `hostRvalid`.
- R3: While disabled, a window write (`hostWr`=1) stores the full 16-bit `hostWdata` at the clock edge that ends the cycle in which it is presented.
- R4: While disabled, a window read (`hostWr`=0) raises `hostRvalid` for one cycle in the following cycle, with `hostRdata` holding the stored word.
- R5: While enabled, a window read still gives `hostRvalid` one cycle later, but `hostRdata` is 0x0000. A window write leaves the RAM unchanged.
- R6: `accessErr` becomes 1 after any window access made while enabled. It then stays 1 until reset.
- R7: A cycle with `ctrlWe`=1 loads `ctrlEnable` into the enable bit. `dspEnable` shows the new value in the next cycle.
- R8: In the first cycle in which `dspEnable` is 1, `dspFetchValid` is 0. In every later enabled cycle, `dspFetchValid` is 1 and `dspInstr` is the word at the `dspPc` presented in the previous cycle.
- R9: In the cycle in which `dspEnable` returns to 0, `dspFetchValid` is already 0, and window reads again return stored data.
- R10: While disabled, `dspFetchValid` stays 0 whatever the value of `dspPc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Main-core data access strobe |
| hostWr | input | 1 | 1 for write, 0 for read |
| hostAddr | input | 16 | Main-core word address |
| hostWdata | input | 16 | Main-core write data |
| hostRdata | output | 16 | Read data, valid with hostRvalid |
| hostRvalid | output | 1 | Window read response, one cycle after the request |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlEnable | input | 1 | Enable bit value written on ctrlWe |
| dspEnable | output | 1 | Current enable bit; 1 means the coprocessor owns the RAM |
| accessErr | output | 1 | Sticky flag for window access while enabled |
| dspPc | input | 12 | Coprocessor fetch address |
| dspInstr | output | 16 | Fetched instruction word |
| dspFetchValid | output | 1 | dspInstr holds a valid fetch |

## Verification
The results of this block fall due at fixed times:

- A main-core read answers exactly one cycle after it is presented, whether it returns stored data or the zero of a blocked access.
- A write shows up only on a later read or fetch.
- An enable change appears on `dspEnable` one cycle after the control write.
- A fetch word arrives one cycle after its `dspPc`. Once the enable bit is set, the first fetch word arrives in the second enabled cycle.

The bench drives all inputs on falling edges and keeps a queue of expected read responses. Each response is popped in the falling-edge sample that follows the rising edge which produced it. Fetch and flag checks are sampled one falling edge after the rising edge that updates them.

// File: rtl/prsw_pkg.sv
package prsw_pkg;
  // Per-cycle strobes from the decode/ownership control to the RAM datapath.
  typedef struct packed {
    logic ramWe;      // write host word into RAM this cycle
    logic ramRd;      // perform a synchronous RAM read this cycle
    logic useDsp;     // read address taken from the fetch port
    logic hostRdHit;  // host read served from RAM
    logic hostRdBlk;  // host read blocked, answer with zero
  } ramStrobe_t;
endpackage

// File: rtl/prsw_ctrl.sv
module prsw_ctrl
  import prsw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RAM_AW = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              ctrlWe,
  input  logic              ctrlEnable,
  output ramStrobe_t        strobe,
  output logic [RAM_AW-1:0] ramIdx,
  output logic              dspEnable,
  output logic              dspFetchValid,
  output logic              accessErr
);
  localparam int DEPTH = 1 << RAM_AW;
  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(DEPTH);

  logic              enReg;
  logic              fvReg;
  logic              errReg;
  logic              winHit;
  logic [ADDR_W-1:0] offset;

  // Window decode
  always_comb begin
    offset = hostAddr - WIN_BASE;
    winHit = hostSel && (hostAddr >= WIN_BASE) && ({1'b0, hostAddr} < WIN_END);
    ramIdx = offset[RAM_AW-1:0];
  end

  // Ownership strobes
  always_comb begin
    strobe.useDsp    = enReg;
    strobe.ramWe     = winHit && hostWr && !enReg;
    strobe.hostRdHit = winHit && !hostWr && !enReg;
    strobe.hostRdBlk = winHit && !hostWr && enReg;
    strobe.ramRd     = enReg || strobe.hostRdHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      fvReg  <= 1'b0;
      errReg <= 1'b0;
    end else begin
      if (ctrlWe) enReg <= ctrlEnable;
      fvReg  <= enReg;
      errReg <= errReg || (winHit && enReg);
    end
  end

  assign dspEnable     = enReg;
  assign dspFetchValid = fvReg && enReg;
  assign accessErr     = errReg;

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |=> accessErr);
  a_r7_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWe |=> (dspEnable == $past(ctrlEnable)));
  a_r8_first_cycle_holdoff: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dspEnable) |-> !dspFetchValid);
  a_r9_stop_at_once: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dspEnable) |-> !dspFetchValid);
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !dspEnable |-> !dspFetchValid);
endmodule

// File: rtl/prsw_dpath.sv
module prsw_dpath
  import prsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RAM_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobe_t        strobe,
  input  logic [RAM_AW-1:0] ramIdx,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [RAM_AW-1:0] dspPc,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic [DATA_W-1:0] dspInstr
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;
  logic [RAM_AW-1:0] rdAddr;
  logic              rdHitQ;
  logic              rdBlkQ;

  assign rdAddr = strobe.useDsp ? dspPc : ramIdx;

  // Single-port array: at most one of write or read per cycle
  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[ramIdx] <= hostWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramQ   <= '0;
      rdHitQ <= 1'b0;
      rdBlkQ <= 1'b0;
    end else begin
      if (strobe.ramRd) ramQ <= mem[rdAddr];
      rdHitQ <= strobe.hostRdHit;
      rdBlkQ <= strobe.hostRdBlk;
    end
  end

  assign hostRvalid = rdHitQ || rdBlkQ;
  assign hostRdata  = rdHitQ ? ramQ : '0;
  assign dspInstr   = ramQ;

  a_r4_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hostRdHit |=> hostRvalid);
  a_r3_single_port: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.ramWe && strobe.ramRd));
  a_r5_no_write_when_owned: assert property (@(posedge clk) disable iff (!rstN)
    strobe.useDsp |-> !strobe.ramWe);
endmodule

// File: rtl/prog_ram_switch.sv
module prog_ram_switch
  import prsw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int RAM_AW = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  input  logic              ctrlWe,
  input  logic              ctrlEnable,
  output logic              dspEnable,
  output logic              accessErr,
  input  logic [RAM_AW-1:0] dspPc,
  output logic [DATA_W-1:0] dspInstr,
  output logic              dspFetchValid
);
  ramStrobe_t        strobe;
  logic [RAM_AW-1:0] ramIdx;

  prsw_ctrl #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .WIN_BASE(WIN_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .ctrlWe(ctrlWe), .ctrlEnable(ctrlEnable),
    .strobe(strobe), .ramIdx(ramIdx), .dspEnable(dspEnable),
    .dspFetchValid(dspFetchValid), .accessErr(accessErr)
  );

  prsw_dpath #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramIdx(ramIdx),
    .hostWdata(hostWdata), .dspPc(dspPc), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid), .dspInstr(dspInstr)
  );

  localparam logic [ADDR_W:0] TOP_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(1 << RAM_AW);

  logic inWindow;
  assign inWindow = (hostAddr >= WIN_BASE) && ({1'b0, hostAddr} < TOP_END);

  a_r5_blocked_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostWr && inWindow && dspEnable) |=> (hostRvalid && hostRdata == '0));
  a_r2_outside_silent: assert property (@(posedge clk) disable iff (!rstN)
    (!(hostSel && !hostWr && inWindow)) |=> !hostRvalid);
  a_r6_err_on_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && inWindow && dspEnable) |=> accessErr);
endmodule

// File: tb/prog_ram_switch_test.sv
module prog_ram_switch_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0;
  logic [15:0] hostAddr = '0, hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostRvalid;
  logic        ctrlWe = 1'b0, ctrlEnable = 1'b0;
  logic        dspEnable, accessErr, dspFetchValid;
  logic [11:0] dspPc = '0;
  logic [15:0] dspInstr;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [4096];
  bit          enModel = 1'b0;
  logic [15:0] expData[$];
  string       expReq[$];

  always #(PERIOD/2) clk = ~clk;

  prog_ram_switch uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostRvalid(hostRvalid), .ctrlWe(ctrlWe), .ctrlEnable(ctrlEnable),
    .dspEnable(dspEnable), .accessErr(accessErr), .dspPc(dspPc),
    .dspInstr(dspInstr), .dspFetchValid(dspFetchValid)
  );

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit inWin(logic [15:0] a);
    return a >= 16'h1000 && a <= 16'h1FFF;
  endfunction

  // Monitor: pops expected read responses as the design produces them
  always @(negedge clk) begin
    if (rstN && hostRvalid) begin
      if (expData.size() == 0) begin
        check(1'b0, "R2 unexpected read response", hostRdata, 16'h0);
      end else begin
        logic [15:0] e;
        string r;
        e = expData.pop_front();
        r = expReq.pop_front();
        check(hostRdata === e, r, hostRdata, e);
      end
    end
  end

  task automatic hostWrite(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    if (inWin(a) && !enModel) model[a - 16'h1000] = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(logic [15:0] a, string req);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    if (inWin(a)) begin
      expData.push_back(enModel ? 16'h0000 : model[a - 16'h1000]);
      expReq.push_back(req);
    end
    @(negedge clk);
    hostSel = 1'b0;
    if (!inWin(a)) check(hostRvalid == 1'b0, "R2 outside read no response", {15'b0, hostRvalid}, 16'h0);
  endtask

  task automatic setEnable(bit v);
    @(negedge clk);
    ctrlWe = 1'b1; ctrlEnable = v;
    @(negedge clk);
    ctrlWe = 1'b0;
    enModel = v;
    check(dspEnable == v, "R7 enable follows control write", {15'b0, dspEnable}, {15'b0, v});
    if (v) check(dspFetchValid == 1'b0, "R8 first enabled cycle not valid", {15'b0, dspFetchValid}, 16'h0);
    else   check(dspFetchValid == 1'b0, "R9 valid drops with enable", {15'b0, dspFetchValid}, 16'h0);
  endtask

  // Present pc, expect its word one cycle later (caller is at a negedge while enabled)
  task automatic fetch(logic [11:0] pc);
    dspPc = pc;
    @(negedge clk);
    check(dspFetchValid == 1'b1, "R8 fetch valid", {15'b0, dspFetchValid}, 16'h1);
    check(dspInstr === model[pc], "R8 fetch data", dspInstr, model[pc]);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(dspEnable == 1'b0, "R1 reset enable", {15'b0, dspEnable}, 16'h0);
    check(dspFetchValid == 1'b0, "R1 reset valid", {15'b0, dspFetchValid}, 16'h0);
    check(accessErr == 1'b0, "R1 reset error flag", {15'b0, accessErr}, 16'h0);
    check(hostRvalid == 1'b0, "R1 reset read valid", {15'b0, hostRvalid}, 16'h0);

    for (int i = 0; i < 4; i++) begin
      dspPc = 12'(i * 1000);
      @(negedge clk);
      check(dspFetchValid == 1'b0, "R10 no fetch while disabled", {15'b0, dspFetchValid}, 16'h0);
    end

    // Load code through the window (R3), including both edges
    hostWrite(16'h1000, 16'hA5A5);
    hostWrite(16'h1FFF, 16'h5A5A);
    hostWrite(16'h1005, 16'h1234);
    hostWrite(16'h1800, 16'hBEEF);
    hostWrite(16'h2005, 16'hDEAD);   // outside: would alias index 0x005 if decode wrapped
    hostWrite(16'h0FFF, 16'hFFFF);   // outside: would alias index 0xFFF
    hostRead(16'h1000, "R3 R4 read window base");
    hostRead(16'h1FFF, "R2 R4 read window top (outside write ignored)");
    hostRead(16'h1005, "R2 R4 read index 5 (outside write ignored)");
    hostRead(16'h1800, "R4 read mid window");
    hostRead(16'h2000, "R2 outside");
    hostWrite(16'h1800, 16'hC0DE);
    hostRead(16'h1800, "R3 overwrite takes effect");
    @(negedge clk);
    check(accessErr == 1'b0, "R6 no error while disabled", {15'b0, accessErr}, 16'h0);

    // Hand RAM to the coprocessor
    setEnable(1'b1);
    fetch(12'h000);
    fetch(12'hFFF);
    fetch(12'h800);
    fetch(12'h005);

    // Blocked main-core accesses
    hostRead(16'h1005, "R5 blocked read returns zero");
    hostWrite(16'h1005, 16'h9999);
    dspPc = 12'h005;
    @(negedge clk);
    check(accessErr == 1'b1, "R6 error set on blocked access", {15'b0, accessErr}, 16'h1);
    @(negedge clk);
    check(dspInstr === 16'h1234, "R5 blocked write left RAM unchanged", dspInstr, 16'h1234);

    // Return ownership
    setEnable(1'b0);
    hostRead(16'h1005, "R9 host owns again, R5 word kept");
    check(accessErr == 1'b1, "R6 error stays set", {15'b0, accessErr}, 16'h1);
    dspPc = 12'h123;
    @(negedge clk);
    check(dspFetchValid == 1'b0, "R10 no fetch after disable", {15'b0, dspFetchValid}, 16'h0);

    // Re-enable and fetch updated word
    setEnable(1'b1);
    fetch(12'h800);

    repeat (3) @(negedge clk);
    check(expData.size() == 0, "R4 all read responses seen", 16'(expData.size()), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule